// File: doc/BRIEF.md
# Effective Address Generator

This block turns a decoded addressing mode into the 24-bit address that an instruction of a 16-bit accumulator processor will touch. Its inputs are the register file values (program counter, program and data bank, direct page base, stack pointer, X and Y), the operand bytes that follow the opcode, an emulation flag and the kind of access. Each result comes with the number of operand bytes, so the caller can advance the program counter, and a cost figure in clock units. The unit also keeps an open-bus byte that follows the last value seen on the data bus.

Modes that need no memory access resolve in one cycle. For the indirect modes, a small sequencer reads a 2-byte or 3-byte little-endian pointer one byte at a time over a byte-wide read port that has a ready handshake. It then combines the pointer with a bank and an optional Y index. A one-cycle `done` strobe marks each result. The result outputs hold their values until a later request replaces them.

Top module: `ea_unit`

## Requirements
- R1: `mode` codes are: 0 imm8, 1 imm16, 2 rel8, 3 rel16, 4 abs, 5 abs+X, 6 abs+Y, 7 long, 8 long+X, 9 dp, 10 dp+X, 11 dp+Y, 12 stack-rel, 13 (sr),Y, 14 (dp), 15 (dp+X), 16 (dp),Y, 17 [dp], 18 [dp],Y, 19 (abs+X), 20 (abs), 21 [abs]. `acc` codes are: 0 none, 1 read, 2 write, 3 read-modify-write, 4 jump. The immediate modes return {pbank, pc}.
- R2: rel8 returns {pbank, (pc + 1 + sign-extended opnd[7:0]) mod 2^16}. rel16 returns {pbank, (pc + 2 + opnd[15:0]) mod 2^16}.
- R3: abs, abs+X and abs+Y return (dbank·2^16 + opnd[15:0] [+X or +Y]) mod 2^24, so a carry from the index reaches the bank. long returns opnd. long+X returns (opnd + X) mod 2^24.
- R4: dp, dp+X and dp+Y return {0x00, (opnd[7:0] + dpage [+X or +Y]) mod 2^16}. When `emu` is 1, dp+X and dp+Y return only the low 8 bits of that sum.
- R5: stack-rel returns {0x00, (opnd[7:0] + sp) mod 2^16}. (sr),Y reads a 16-bit pointer at that location and returns (dbank·2^16 + pointer + Y) mod 2^24.
- R6: (dp), (dp+X) and (dp),Y read a 16-bit pointer at {0x00, opnd[7:0] + dpage [+X] mod 2^16}. The emulation flag has no effect on that location. The result is dbank·2^16 + pointer, plus Y for (dp),Y, mod 2^24.
- R7: [dp] and [dp],Y read a 24-bit pointer at {0x00, opnd[7:0] + dpage}. [dp],Y adds Y to the full 24-bit pointer, mod 2^24.
- R8: (abs+X) reads its pointer at {pbank, (opnd[15:0] + X) mod 2^16} and returns {pbank, pointer}. (abs) reads at {0x00, opnd[15:0]} and returns {pbank, pointer}. [abs] reads a 24-bit pointer at {0x00, opnd[15:0]}.
- R9: The pointer bytes are read at offsets +0, +1 and +2 from the pointer location, with the 16-bit offset wrapping inside the pointer's bank. A pointer at 0x00FFFF takes its high byte from 0x000000.
- R10: When a result is presented, `obus` updates as follows. For the indirect modes (13 to 21), it takes the last pointer byte on a read or read-modify-write access, and the last operand byte otherwise. For modes 4 to 12, it takes the last operand byte on a read or read-modify-write access, and is unchanged otherwise. For modes 0 to 3 it is unchanged.
- R11: `nbytes` is 1 for modes 0, 2 and 9 to 18, 2 for modes 1, 3 to 6 and 19 to 21, and 3 for modes 7 and 8. `cost` is 0 for the immediate modes. For all other modes it is nbytes·MEM_SPD + k·IO_CYC, where k is 1 for rel16, dp+X, dp+Y, stack-rel and (dp+X), 2 for (sr),Y, and 0 otherwise.
- R12: A `start` accepted for modes 0 to 12 gives `done` in the next cycle. `done` lasts one cycle unless a new request is accepted. `ea`, `nbytes` and `cost` change only in a `done` cycle.
- R13: Each pointer byte is one `mem_rd` cycle or a run of them. `mem_addr` holds steady until `mem_rdy` is seen, and `mem_rd` is low whenever `done` is high.
- R14: A `start` that arrives while a pointer fetch is in progress is ignored. The fetch continues and completes with the original request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; accepted when no fetch is running |
| mode | input | 5 | Addressing mode code (R1) |
| acc | input | 3 | Access kind code (R1) |
| emu | input | 1 | Emulation flag for direct-page indexed wrap |
| pc | input | 16 | Address of the first operand byte |
| pbank | input | 8 | Program bank |
| dbank | input | 8 | Data bank |
| dpage | input | 16 | Direct page base |
| sp | input | 16 | Stack pointer |
| xr | input | 16 | X index |
| yr | input | 16 | Y index |
| opnd | input | 24 | Operand bytes, first byte in bits 7:0 |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_rdata | input | 8 | Read data |
| mem_rdy | input | 1 | Read data valid this cycle |
| done | output | 1 | Result strobe |
| ea | output | 24 | Effective address |
| nbytes | output | 2 | Operand byte count |
| cost | output | COST_W | Cycle cost |
| obus | output | 8 | Open-bus byte |

## Verification
The bench uses the default parameters: MEM_SPD 8, IO_CYC 6, COST_W 8, with the emulation wrap and the open-bus latch both enabled. This keeps the 8-bit direct-indexed wrap and every open-bus update path in the checked logic. Because the two cost weights differ, a swap between an operand-byte term and an internal-cycle term shows up as a wrong value. A memory that stalls at random exercises every pointer-fetch state with waits of varying length. Directed vectors cover a pointer at the top of bank 0, carries out of the index addition, and a start request issued during a stalled fetch.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int BYTE_W = 8;
   localparam int OFS_W  = 16;
   localparam int BANK_W = 8;
   localparam int ADDR_W = BANK_W + OFS_W;
   localparam int MODE_W = 5;
   localparam int ACC_W  = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_IMM8      = 5'd0,
      AM_IMM16     = 5'd1,
      AM_REL8      = 5'd2,
      AM_REL16     = 5'd3,
      AM_ABS       = 5'd4,
      AM_ABS_X     = 5'd5,
      AM_ABS_Y     = 5'd6,
      AM_LONG      = 5'd7,
      AM_LONG_X    = 5'd8,
      AM_DP        = 5'd9,
      AM_DP_X      = 5'd10,
      AM_DP_Y      = 5'd11,
      AM_SR        = 5'd12,
      AM_SR_IND_Y  = 5'd13,
      AM_DP_IND    = 5'd14,
      AM_DP_X_IND  = 5'd15,
      AM_DP_IND_Y  = 5'd16,
      AM_DP_LIND   = 5'd17,
      AM_DP_LIND_Y = 5'd18,
      AM_ABS_X_IND = 5'd19,
      AM_ABS_IND   = 5'd20,
      AM_ABS_LIND  = 5'd21
   } mode_e;

   typedef enum logic [ACC_W-1:0] {
      ACC_NONE = 3'd0,
      ACC_RD   = 3'd1,
      ACC_WR   = 3'd2,
      ACC_RMW  = 3'd3,
      ACC_JMP  = 3'd4
   } acc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LO,
      ST_HI,
      ST_BANK,
      ST_DONE
   } fsm_e;

   // Decoded view of one request, produced combinationally
   typedef struct packed {
      logic              ind;      // needs a pointer fetch
      logic              plong;    // pointer is three bytes
      logic              obclass;  // direct result that feeds open bus on reads
      logic [ADDR_W-1:0] loc;      // pointer location
      logic [BANK_W-1:0] fbank;    // bank placed over a 16-bit pointer
      logic [OFS_W-1:0]  idx;      // index added after pointer assembly
      logic [ADDR_W-1:0] ea;       // final address for direct modes
   } prep_t;
endpackage

// File: rtl/ea_prep.sv
module ea_prep
   import ea_pkg::*;
#(
   parameter bit EMU_WRAP_EN = 1'b1
) (
   input  mode_e             mode,
   input  logic              emu,
   input  logic [OFS_W-1:0]  pc,
   input  logic [BANK_W-1:0] pbank,
   input  logic [BANK_W-1:0] dbank,
   input  logic [OFS_W-1:0]  dpage,
   input  logic [OFS_W-1:0]  sp,
   input  logic [OFS_W-1:0]  xr,
   input  logic [OFS_W-1:0]  yr,
   input  logic [ADDR_W-1:0] opnd,
   output prep_t             p
);
   localparam logic [BANK_W-1:0] ZB = '0;

   logic [OFS_W-1:0]  op16, op8, sx8;
   logic [OFS_W-1:0]  dp_sum, dpx_sum, dpy_sum, sr_sum;
   logic [OFS_W-1:0]  dpx_w, dpy_w, rel_s, rel_l, absx_ofs;
   logic [ADDR_W-1:0] dbase;
   logic              emu_eff;

   assign op16 = opnd[OFS_W-1:0];
   assign op8  = {{(OFS_W-BYTE_W){1'b0}}, opnd[BYTE_W-1:0]};
   assign sx8  = {{(OFS_W-BYTE_W){opnd[BYTE_W-1]}}, opnd[BYTE_W-1:0]};

   assign dp_sum   = op8 + dpage;
   assign dpx_sum  = dp_sum + xr;
   assign dpy_sum  = dp_sum + yr;
   assign sr_sum   = op8 + sp;
   assign rel_s    = pc + 16'd1 + sx8;
   assign rel_l    = pc + 16'd2 + op16;
   assign absx_ofs = op16 + xr;
   assign dbase    = {dbank, {OFS_W{1'b0}}};

   // Variant choice: emulation narrowing present or not
   generate
      if (EMU_WRAP_EN) begin : g_emu
         assign emu_eff = emu;
      end else begin : g_noemu
         assign emu_eff = 1'b0;
      end
   endgenerate

   assign dpx_w = emu_eff ? {{(OFS_W-BYTE_W){1'b0}}, dpx_sum[BYTE_W-1:0]} : dpx_sum;
   assign dpy_w = emu_eff ? {{(OFS_W-BYTE_W){1'b0}}, dpy_sum[BYTE_W-1:0]} : dpy_sum;

   always_comb begin
      p       = '0;
      p.fbank = dbank;
      p.ea    = {pbank, pc};
      unique case (mode)
         AM_IMM8, AM_IMM16: p.ea = {pbank, pc};
         AM_REL8:   p.ea = {pbank, rel_s};
         AM_REL16:  p.ea = {pbank, rel_l};
         AM_ABS:    begin p.ea = dbase + {ZB, op16};             p.obclass = 1'b1; end
         AM_ABS_X:  begin p.ea = dbase + {ZB, op16} + {ZB, xr};  p.obclass = 1'b1; end
         AM_ABS_Y:  begin p.ea = dbase + {ZB, op16} + {ZB, yr};  p.obclass = 1'b1; end
         AM_LONG:   begin p.ea = opnd;                           p.obclass = 1'b1; end
         AM_LONG_X: begin p.ea = opnd + {ZB, xr};                p.obclass = 1'b1; end
         AM_DP:     begin p.ea = {ZB, dp_sum};                   p.obclass = 1'b1; end
         AM_DP_X:   begin p.ea = {ZB, dpx_w};                    p.obclass = 1'b1; end
         AM_DP_Y:   begin p.ea = {ZB, dpy_w};                    p.obclass = 1'b1; end
         AM_SR:     begin p.ea = {ZB, sr_sum};                   p.obclass = 1'b1; end
         AM_SR_IND_Y: begin
            p.ind = 1'b1; p.loc = {ZB, sr_sum}; p.idx = yr;
         end
         AM_DP_IND: begin
            p.ind = 1'b1; p.loc = {ZB, dp_sum};
         end
         AM_DP_X_IND: begin
            p.ind = 1'b1; p.loc = {ZB, dpx_sum};
         end
         AM_DP_IND_Y: begin
            p.ind = 1'b1; p.loc = {ZB, dp_sum}; p.idx = yr;
         end
         AM_DP_LIND: begin
            p.ind = 1'b1; p.plong = 1'b1; p.loc = {ZB, dp_sum};
         end
         AM_DP_LIND_Y: begin
            p.ind = 1'b1; p.plong = 1'b1; p.loc = {ZB, dp_sum}; p.idx = yr;
         end
         AM_ABS_X_IND: begin
            p.ind = 1'b1; p.loc = {pbank, absx_ofs}; p.fbank = pbank;
         end
         AM_ABS_IND: begin
            p.ind = 1'b1; p.loc = {ZB, op16}; p.fbank = pbank;
         end
         AM_ABS_LIND: begin
            p.ind = 1'b1; p.plong = 1'b1; p.loc = {ZB, op16};
         end
         default: p.ea = {pbank, pc};
      endcase
   end
endmodule

// File: rtl/ea_cost.sv
module ea_cost
   import ea_pkg::*;
#(
   parameter int MEM_SPD = 8,
   parameter int IO_CYC  = 6,
   parameter int COST_W  = 8,
   parameter int NB_W    = 2
) (
   input  mode_e             mode,
   output logic [NB_W-1:0]   nbytes,
   output logic [COST_W-1:0] cost
);
   localparam logic [COST_W-1:0] SPD_C = COST_W'(MEM_SPD);
   localparam logic [COST_W-1:0] IO_C  = COST_W'(IO_CYC);

   logic [1:0] internal;
   logic       free;

   always_comb begin
      internal = 2'd0;
      free     = 1'b0;
      nbytes   = NB_W'(1);
      unique case (mode)
         AM_IMM8:      free = 1'b1;
         AM_IMM16:     begin free = 1'b1; nbytes = NB_W'(2); end
         AM_REL16:     begin nbytes = NB_W'(2); internal = 2'd1; end
         AM_ABS, AM_ABS_X, AM_ABS_Y,
         AM_ABS_X_IND, AM_ABS_IND, AM_ABS_LIND:
                       nbytes = NB_W'(2);
         AM_LONG, AM_LONG_X:
                       nbytes = NB_W'(3);
         AM_DP_X, AM_DP_Y, AM_SR, AM_DP_X_IND:
                       internal = 2'd1;
         AM_SR_IND_Y:  internal = 2'd2;
         default:      nbytes = NB_W'(1);
      endcase
   end

   // Weighted sum of operand fetches and internal cycles
   always_comb begin
      if (free) cost = '0;
      else      cost = COST_W'(nbytes) * SPD_C + COST_W'(internal) * IO_C;
   end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch
   import ea_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_ind,
   input  logic              go_dir,
   input  logic [ADDR_W-1:0] loc,
   input  logic              plong,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output fsm_e              st,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] ptr,
   output logic              last_beat
);
   logic [ADDR_W-1:0] loc_r;
   logic              long_r;
   logic [BYTE_W-1:0] lo_r, hi_r;
   logic [OFS_W-1:0]  step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         loc_r  <= '0;
         long_r <= 1'b0;
         lo_r   <= '0;
         hi_r   <= '0;
      end else begin
         unique case (st)
            ST_IDLE, ST_DONE: begin
               if (go_ind) begin
                  st     <= ST_LO;
                  loc_r  <= loc;
                  long_r <= plong;
               end else if (go_dir) begin
                  st <= ST_DONE;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_LO: if (mem_rdy) begin
               lo_r <= mem_rdata;
               st   <= ST_HI;
            end
            ST_HI: if (mem_rdy) begin
               hi_r <= mem_rdata;
               st   <= long_r ? ST_BANK : ST_DONE;
            end
            ST_BANK: if (mem_rdy) st <= ST_DONE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         ST_HI:   step = 16'd1;
         ST_BANK: step = 16'd2;
         default: step = 16'd0;
      endcase
   end

   assign mem_rd    = (st == ST_LO) || (st == ST_HI) || (st == ST_BANK);
   assign mem_addr  = {loc_r[ADDR_W-1:OFS_W], loc_r[OFS_W-1:0] + step};
   assign last_beat = mem_rdy && (((st == ST_HI) && !long_r) || (st == ST_BANK));
   assign ptr = {(st == ST_BANK) ? mem_rdata : {BYTE_W{1'b0}},
                 (st == ST_HI)   ? mem_rdata : hi_r,
                 lo_r};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
   import ea_pkg::*;
#(
   parameter int MEM_SPD     = 8,
   parameter int IO_CYC      = 6,
   parameter int COST_W      = 8,
   parameter int NB_W        = 2,
   parameter bit EMU_WRAP_EN = 1'b1,
   parameter bit OPEN_BUS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [4:0]        mode,
   input  logic [2:0]        acc,
   input  logic              emu,
   input  logic [15:0]       pc,
   input  logic [7:0]        pbank,
   input  logic [7:0]        dbank,
   input  logic [15:0]       dpage,
   input  logic [15:0]       sp,
   input  logic [15:0]       xr,
   input  logic [15:0]       yr,
   input  logic [23:0]       opnd,
   output logic              mem_rd,
   output logic [23:0]       mem_addr,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_rdy,
   output logic              done,
   output logic [23:0]       ea,
   output logic [NB_W-1:0]   nbytes,
   output logic [COST_W-1:0] cost,
   output logic [7:0]        obus
);
   localparam int MAX_COST = 3 * MEM_SPD + 2 * IO_CYC;

   // Elaboration-time parameter checks
   if (MAX_COST >= (1 << COST_W)) begin : g_bad_cost
      $error("ea_unit: COST_W too narrow for MEM_SPD and IO_CYC");
   end
   if (NB_W < 2) begin : g_bad_nb
      $error("ea_unit: NB_W must hold the value 3");
   end
   if (ADDR_W != 24 || BYTE_W != 8) begin : g_bad_addr
      $error("ea_unit: address layout must be an 8-bit bank over a 16-bit offset");
   end

   mode_e             mode_c;
   prep_t             pr;
   logic [NB_W-1:0]   nb_c;
   logic [COST_W-1:0] cost_c;
   logic [BYTE_W-1:0] lastop_c;
   logic              acc_rd;
   logic              accept, go_ind, go_dir, busy, last_beat;
   logic [ADDR_W-1:0] ptr, ind_ea;
   fsm_e              st;

   assign mode_c = mode_e'(mode);
   assign acc_rd = (acc == ACC_RD) || (acc == ACC_RMW);

   ea_prep #(.EMU_WRAP_EN(EMU_WRAP_EN)) u_prep (
      .mode(mode_c), .emu(emu), .pc(pc), .pbank(pbank), .dbank(dbank),
      .dpage(dpage), .sp(sp), .xr(xr), .yr(yr), .opnd(opnd), .p(pr)
   );

   ea_cost #(.MEM_SPD(MEM_SPD), .IO_CYC(IO_CYC), .COST_W(COST_W), .NB_W(NB_W)) u_cost (
      .mode(mode_c), .nbytes(nb_c), .cost(cost_c)
   );

   always_comb begin
      if (nb_c == NB_W'(3))      lastop_c = opnd[23:16];
      else if (nb_c == NB_W'(2)) lastop_c = opnd[15:8];
      else                       lastop_c = opnd[7:0];
   end

   assign busy   = (st == ST_LO) || (st == ST_HI) || (st == ST_BANK);
   assign accept = start && !busy;
   assign go_ind = accept && pr.ind;
   assign go_dir = accept && !pr.ind;

   ea_fetch u_fetch (
      .clk(clk), .rst_n(rst_n), .go_ind(go_ind), .go_dir(go_dir),
      .loc(pr.loc), .plong(pr.plong), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .st(st), .mem_rd(mem_rd), .mem_addr(mem_addr), .ptr(ptr), .last_beat(last_beat)
   );

   assign done = (st == ST_DONE);

   // Request context held across the pointer fetch
   logic [BANK_W-1:0] fbank_l;
   logic [OFS_W-1:0]  idx_l;
   logic              plong_l, rd_l;
   logic [NB_W-1:0]   nb_l;
   logic [COST_W-1:0] cost_l;
   logic [BYTE_W-1:0] lastop_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fbank_l  <= '0;
         idx_l    <= '0;
         plong_l  <= 1'b0;
         rd_l     <= 1'b0;
         nb_l     <= '0;
         cost_l   <= '0;
         lastop_l <= '0;
      end else if (accept) begin
         fbank_l  <= pr.fbank;
         idx_l    <= pr.idx;
         plong_l  <= pr.plong;
         rd_l     <= acc_rd;
         nb_l     <= nb_c;
         cost_l   <= cost_c;
         lastop_l <= lastop_c;
      end
   end

   assign ind_ea = (plong_l ? ptr : {fbank_l, ptr[OFS_W-1:0]}) + {{BANK_W{1'b0}}, idx_l};

   logic [ADDR_W-1:0] ea_r;
   logic [NB_W-1:0]   nb_r;
   logic [COST_W-1:0] cost_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_r   <= '0;
         nb_r   <= '0;
         cost_r <= '0;
      end else if (go_dir) begin
         ea_r   <= pr.ea;
         nb_r   <= nb_c;
         cost_r <= cost_c;
      end else if (last_beat) begin
         ea_r   <= ind_ea;
         nb_r   <= nb_l;
         cost_r <= cost_l;
      end
   end

   assign ea     = ea_r;
   assign nbytes = nb_r;
   assign cost   = cost_r;

   generate
      if (OPEN_BUS_EN) begin : g_ob
         logic [BYTE_W-1:0] ob_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               ob_r <= '0;
            else if (go_dir && pr.obclass && acc_rd)  ob_r <= lastop_c;
            else if (last_beat)                       ob_r <= rd_l ? mem_rdata : lastop_l;
         end
         assign obus = ob_r;
      end else begin : g_no_ob
         assign obus = '0;
      end
   endgenerate
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
   parameter int COST_W = 8,
   parameter int NB_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [4:0]        mode,
   input logic              done,
   input logic              mem_rd,
   input logic              mem_rdy,
   input logic [23:0]       mem_addr,
   input logic [23:0]       ea,
   input logic [NB_W-1:0]   nbytes,
   input logic [COST_W-1:0] cost,
   input logic              busy
);
   // R12: direct modes answer in the cycle after acceptance
   a_r12_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode <= 5'd12) |=> done);

   // R12: strobe is a single cycle when no new request is accepted
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R12: results move only together with the strobe
   a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ea) && $stable(nbytes) && $stable(cost)));

   // R13: address held while the memory stalls
   a_r13_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

   // R13: no read is issued while a result is presented
   a_r13_no_read_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd);

   // R11: every result carries a nonzero byte count
   a_r11_nbytes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (nbytes != '0));

   // R14: a request during a stalled fetch does not end the fetch
   a_r14_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !mem_rdy) |=> busy);
endmodule

bind ea_unit ea_unit_chk #(.COST_W(COST_W), .NB_W(NB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .done(done),
   .mem_rd(mem_rd), .mem_rdy(mem_rdy), .mem_addr(mem_addr), .ea(ea),
   .nbytes(nbytes), .cost(cost), .busy(busy)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
   localparam int CLK_P    = 10;
   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  mode = '0;
   logic [2:0]  acc = '0;
   logic        emu = 1'b0;
   logic [15:0] pc = '0, dpage = '0, sp = '0, xr = '0, yr = '0;
   logic [7:0]  pbank = '0, dbank = '0;
   logic [23:0] opnd = '0;
   logic        mem_rd, mem_rdy = 1'b1, done;
   logic [23:0] mem_addr, ea;
   logic [7:0]  mem_rdata, obus;
   logic [1:0]  nbytes;
   logic [7:0]  cost;

   int n_chk = 0, n_bad = 0;
   int rdy_mode = 0; // 0 random, 1 stall, 2 always ready

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] mb(input logic [23:0] a);
      logic [7:0] t;
      t = a[7:0] * 8'd37;
      return t ^ a[15:8] ^ (a[23:16] + 8'h5A);
   endfunction

   assign mem_rdata = mb(mem_addr);

   ea_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc), .emu(emu),
      .pc(pc), .pbank(pbank), .dbank(dbank), .dpage(dpage), .sp(sp), .xr(xr), .yr(yr),
      .opnd(opnd), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_rdy(mem_rdy), .done(done), .ea(ea), .nbytes(nbytes), .cost(cost), .obus(obus)
   );

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rdy_mode == 1)      mem_rdy = 1'b0;
         else if (rdy_mode == 2) mem_rdy = 1'b1;
         else                    mem_rdy = ($urandom % 3) != 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference model state
   logic [23:0] e_ea, e_loc;
   int          e_nb, e_cost;
   logic [7:0]  e_ob = 8'h00;

   function automatic string tag_of(input int md);
      if (md <= 1)  return "R1";
      if (md <= 3)  return "R2";
      if (md <= 8)  return "R3";
      if (md <= 11) return "R4";
      if (md <= 13) return "R5";
      if (md <= 16) return "R6";
      if (md <= 18) return "R7";
      return "R8";
   endfunction

   task automatic model(input int md, input int ac, input bit em);
      int          t, ic;
      bit          ind, lng, rd;
      logic [7:0]  fb, last_ptr, last_op, lo, hi, bk;
      logic [15:0] ix, off;
      logic [23:0] base;
      ind = 0; lng = 0; ix = 0; fb = dbank; e_loc = 0; ic = 0;
      case (md)
         0, 1: e_ea = {pbank, pc};
         2: begin t = int'(pc) + 1 + int'($signed(opnd[7:0])); e_ea = {pbank, t[15:0]}; end
         3: begin t = int'(pc) + 2 + int'(opnd[15:0]); e_ea = {pbank, t[15:0]}; ic = 1; end
         4: e_ea = {dbank, opnd[15:0]};
         5: begin t = (int'(dbank) << 16) + int'(opnd[15:0]) + int'(xr); e_ea = t[23:0]; end
         6: begin t = (int'(dbank) << 16) + int'(opnd[15:0]) + int'(yr); e_ea = t[23:0]; end
         7: e_ea = opnd;
         8: begin t = int'(opnd) + int'(xr); e_ea = t[23:0]; end
         9: begin t = int'(opnd[7:0]) + int'(dpage); e_ea = {8'h00, t[15:0]}; end
         10, 11: begin
            t = int'(opnd[7:0]) + int'(dpage) + int'((md == 10) ? xr : yr);
            e_ea = em ? {16'h0000, t[7:0]} : {8'h00, t[15:0]}; ic = 1;
         end
         12: begin t = int'(opnd[7:0]) + int'(sp); e_ea = {8'h00, t[15:0]}; ic = 1; end
         13: begin t = int'(opnd[7:0]) + int'(sp); e_loc = {8'h00, t[15:0]}; ix = yr; ind = 1; ic = 2; end
         14, 16, 17, 18: begin
            t = int'(opnd[7:0]) + int'(dpage); e_loc = {8'h00, t[15:0]}; ind = 1;
            if (md == 16 || md == 18) ix = yr;
            lng = (md >= 17);
         end
         15: begin t = int'(opnd[7:0]) + int'(dpage) + int'(xr); e_loc = {8'h00, t[15:0]}; ind = 1; ic = 1; end
         19: begin t = int'(opnd[15:0]) + int'(xr); e_loc = {pbank, t[15:0]}; ind = 1; fb = pbank; end
         20: begin e_loc = {8'h00, opnd[15:0]}; ind = 1; fb = pbank; end
         default: begin e_loc = {8'h00, opnd[15:0]}; ind = 1; lng = 1; end
      endcase
      if (md == 7 || md == 8) e_nb = 3;
      else if (md == 1 || (md >= 3 && md <= 6) || md >= 19) e_nb = 2;
      else e_nb = 1;
      e_cost = (md <= 1) ? 0 : e_nb * 8 + ic * 6;
      last_op = opnd[8*e_nb-1 -: 8];
      rd = (ac == 1) || (ac == 3);
      if (ind) begin
         off = e_loc[15:0];
         lo = mb(e_loc);
         hi = mb({e_loc[23:16], 16'(off + 16'd1)});
         bk = mb({e_loc[23:16], 16'(off + 16'd2)});
         base = lng ? {bk, hi, lo} : {fb, hi, lo};
         t = int'(base) + int'(ix);
         e_ea = t[23:0];
         last_ptr = lng ? bk : hi;
         e_ob = rd ? last_ptr : last_op;
      end else if (md >= 4 && rd) begin
         e_ob = last_op;
      end
   endtask

   task automatic drive(input int md, input int ac, input bit em,
                        input logic [15:0] pc_i, input logic [7:0] pb_i, input logic [7:0] db_i,
                        input logic [15:0] d_i, input logic [15:0] s_i, input logic [15:0] x_i,
                        input logic [15:0] y_i, input logic [23:0] op_i);
      mode = 5'(md); acc = 3'(ac); emu = em; pc = pc_i; pbank = pb_i; dbank = db_i;
      dpage = d_i; sp = s_i; xr = x_i; yr = y_i; opnd = op_i;
   endtask

   task automatic apply(input string tag_ea, input int md, input int ac, input bit em,
                        input logic [15:0] pc_i, input logic [7:0] pb_i, input logic [7:0] db_i,
                        input logic [15:0] d_i, input logic [15:0] s_i, input logic [15:0] x_i,
                        input logic [15:0] y_i, input logic [23:0] op_i);
      int n;
      string tg;
      @(negedge clk);
      drive(md, ac, em, pc_i, pb_i, db_i, d_i, s_i, x_i, y_i, op_i);
      model(md, ac, em);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (md <= 12) chk("R12 latency", 32'(done), 32'd1);
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      tg = (tag_ea == "") ? tag_of(md) : tag_ea;
      chk(tg, 32'(ea), 32'(e_ea));
      chk("R11 nbytes", 32'(nbytes), 32'(e_nb));
      chk("R11 cost", 32'(cost), 32'(e_cost));
      chk("R10 obus", 32'(obus), 32'(e_ob));
      @(negedge clk);
      chk("R12 pulse", 32'(done), 32'd0);
      chk("R12 hold", 32'(ea), 32'(e_ea));
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12 R13 R10 reset state
      chk("R12 reset done", 32'(done), 32'd0);
      chk("R12 reset ea", 32'(ea), 32'd0);
      chk("R13 reset mem_rd", 32'(mem_rd), 32'd0);
      chk("R10 reset obus", 32'(obus), 32'd0);
      rst_n = 1'b1;

      // Directed corners
      apply("R1 imm", 1, 1, 0, 16'h8000, 8'h7E, 8'h11, 0, 0, 0, 0, 24'h00BEEF);
      apply("R2 back", 2, 0, 0, 16'h0001, 8'h03, 8'h00, 0, 0, 0, 0, 24'h000080);
      apply("R2 long", 3, 4, 0, 16'hFFF0, 8'h03, 8'h00, 0, 0, 0, 0, 24'h000020);
      apply("R3 carry", 5, 1, 0, 0, 0, 8'h12, 0, 0, 16'hFFFF, 0, 24'h00FFFF);
      apply("R3 wrap", 8, 3, 0, 0, 0, 0, 0, 0, 16'h0002, 0, 24'hFFFFFF);
      apply("R4 emu", 10, 1, 1, 0, 0, 0, 16'h1234, 0, 16'h0025, 0, 24'h0000F0);
      apply("R4 native", 10, 1, 0, 0, 0, 0, 16'h1234, 0, 16'h0025, 0, 24'h0000F0);
      apply("R5 carry", 13, 1, 0, 0, 0, 8'hFF, 0, 16'h01F0, 0, 16'hFFFF, 24'h000005);
      apply("R9 top", 14, 1, 0, 0, 0, 8'h44, 16'hFF00, 0, 0, 0, 24'h0000FF);
      apply("R6 emu", 15, 2, 1, 0, 0, 8'h10, 16'h00F0, 0, 16'h0020, 0, 24'h000030);
      apply("R7 index", 18, 1, 0, 0, 0, 0, 16'h0100, 0, 0, 16'hFFFF, 24'h000010);
      apply("R9 pbank", 19, 4, 0, 0, 8'h05, 0, 0, 0, 16'h0001, 0, 24'h00FFFF);
      apply("R8 long", 21, 1, 0, 0, 0, 0, 0, 0, 0, 0, 24'h00FFFE);
      apply("R10 write", 12, 2, 0, 0, 0, 0, 0, 16'h0100, 0, 0, 24'h000033);

      // R14 R13: request during a stalled fetch
      rdy_mode = 1;
      @(negedge clk);
      drive(16, 1, 0, 0, 0, 8'h22, 16'h0300, 0, 0, 16'h0010, 24'h000040);
      model(16, 1, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R13 read", 32'(mem_rd), 32'd1);
      chk("R13 addr", 32'(mem_addr), 32'(e_loc));
      drive(4, 1, 0, 0, 0, 8'h99, 0, 0, 0, 0, 24'h001234);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R14 no done", 32'(done), 32'd0);
      chk("R14 addr", 32'(mem_addr), 32'(e_loc));
      rdy_mode = 2;
      begin
         int n = 0;
         while (!done && n < 50) begin @(negedge clk); n++; end
      end
      chk("R14 result", 32'(ea), 32'(e_ea));
      chk("R10 obus", 32'(obus), 32'(e_ob));
      rdy_mode = 0;

      // Constrained random mix
      for (int i = 0; i < 400; i++) begin
         apply("", int'($urandom_range(0, 21)), int'($urandom_range(0, 4)), 1'($urandom),
               16'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), 24'($urandom));
      end
      report();
   end
endmodule